// File: doc/BRIEF.md
# Memory Power-Up and DLL-Lock Sequencer

This controller-side state machine brings an external synchronous DDR SRAM out of power-off and into operation. It switches on the three supply rails one at a time: core first, then I/O, then the reference voltage. Each rail waits for its power-good flag, with a timeout. Throughout this bring-up the device's DLL control line is held low. Once every rail is good and the memory clock is reported stable, the sequencer raises the DLL control. It then counts a fixed lock interval before it declares the memory ready.

Some boards strap the device's DLL control high. For these boards a mode input selects a different path: the sequencer stops the memory clock for a minimum interval and then restarts it. The lock count runs after the clock restarts. A frequency-change request or a loss of clock stability sends the sequencer back to the clock-wait step, with the DLL control low and ready dropped. A full lock count must then complete again.

All flag inputs pass through a two-stage synchronizer before the state machine sees them. The operating frequency is a parameter. If it is below the DLL's minimum of 119 MHz, the sequencer refuses to enable the DLL and raises the fault flag.

Top module: `mem_pwrup_seq`

## Requirements
- R1: While reset is asserted, all rail enables, `dll_on`, `ready`, `fault` and `mclk_run` are low and `state_dbg` reads 0.
- R2: Rails come up in order: `core_en` first, then `io_en` only after core power-good, then `vref_en` only after I/O power-good. The sequencer moves to the clock-wait step only after reference power-good.
- R3: With `vref_with_io` high, `vref_en` rises in the same cycle as `io_en`. The sequencer waits for both I/O and reference power-good and never enters state 3.
- R4: `dll_on` stays low until all rails are good and `clk_stable` is high. While waiting for the clock, the state is 4 and `mclk_run` is high.
- R5: `ready` rises exactly `LOCK_CYCLES` (1024) cycles after `dll_on` rises.
- R6: With `dll_strap_hi` high, `mclk_run` goes low for exactly `STOP_CYCLES` cycles once the clock is stable. `STOP_CYCLES` defaults to ceil(30 ns × `CLK_MHZ`), which is 6 at 200 MHz. `dll_on` and `mclk_run` then rise in the same cycle.
- R7: A frequency-change request in the lock or ready state drops `dll_on` and `ready` and returns the state to 4. The request takes precedence over lock completion when both fall in the same cycle. `ready` returns only after a fresh full lock count.
- R8: Loss of `clk_stable` during the lock count or in the ready state returns the state to 4 and drops `ready`. The lock count restarts when the clock is stable again.
- R9: If `CLK_MHZ` is below 119, the sequencer enters the fault state (8) when the clock becomes stable and never raises `dll_on`.
- R10: If a rail's power-good does not arrive within `PG_TIMEOUT` cycles of entering its wait state, `fault` rises exactly `PG_TIMEOUT` cycles after entry and all enables drop. The fault state holds until reset.
- R11: `state_dbg` encodes the states as 0 off, 1 core, 2 I/O, 3 reference, 4 clock wait, 5 clock stop, 6 lock, 7 ready and 8 fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_pg | input | 1 | Core rail power-good |
| io_pg | input | 1 | I/O rail power-good |
| vref_pg | input | 1 | Reference rail power-good |
| clk_stable | input | 1 | Memory clock is stable |
| freq_chg_req | input | 1 | Frequency change, forces DLL reset |
| dll_strap_hi | input | 1 | Board straps the DLL control high |
| vref_with_io | input | 1 | Enable reference together with I/O rail |
| core_en | output | 1 | Core rail enable |
| io_en | output | 1 | I/O rail enable |
| vref_en | output | 1 | Reference rail enable |
| dll_on | output | 1 | DLL control to the memory (high enables) |
| mclk_run | output | 1 | Memory clock gate, high lets the clock run |
| ready | output | 1 | Memory ready for traffic |
| fault | output | 1 | Timeout or frequency error |
| state_dbg | output | 4 | Current state encoding |

## Verification
Two events can land in the same cycle: the last cycle of the lock count and a frequency-change request. Both want to change the state in that cycle, one toward ready and one toward the clock-wait step. The bench measures the rise of `dll_on` and places a one-cycle request so that, after the synchronizer, it reaches the state machine in exactly the final count cycle. The outcome is judged at the ports: `ready` must not appear, the state must read 4 on the next cycle, and a complete second count of 1024 cycles must run before `ready` rises.

// File: rtl/mps_pkg.sv
package mps_pkg;
  typedef enum logic [3:0] {
    ST_OFF     = 4'd0,
    ST_CORE    = 4'd1,
    ST_IO      = 4'd2,
    ST_VREF    = 4'd3,
    ST_CLKWAIT = 4'd4,
    ST_STOP    = 4'd5,
    ST_LOCK    = 4'd6,
    ST_READY   = 4'd7,
    ST_FAULT   = 4'd8
  } mps_state_e;
endpackage

// File: rtl/mps_sync.sv
module mps_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mps_timer.sv
module mps_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clr)       cnt <= '0;
    else if (cnt != '1) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mem_pwrup_seq.sv
module mem_pwrup_seq
  import mps_pkg::*;
#(
  parameter int CLK_MHZ     = 200,
  parameter int MIN_DLL_MHZ = 119,
  parameter int LOCK_CYCLES = 1024,
  parameter int STOP_CYCLES = ((30 * CLK_MHZ + 999) / 1000 < 1) ? 1 : (30 * CLK_MHZ + 999) / 1000,
  parameter int PG_TIMEOUT  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       core_pg,
  input  logic       io_pg,
  input  logic       vref_pg,
  input  logic       clk_stable,
  input  logic       freq_chg_req,
  input  logic       dll_strap_hi,
  input  logic       vref_with_io,
  output logic       core_en,
  output logic       io_en,
  output logic       vref_en,
  output logic       dll_on,
  output logic       mclk_run,
  output logic       ready,
  output logic       fault,
  output logic [3:0] state_dbg
);
  localparam int  MAX_A   = (LOCK_CYCLES > PG_TIMEOUT) ? LOCK_CYCLES : PG_TIMEOUT;
  localparam int  MAX_C   = (MAX_A > STOP_CYCLES) ? MAX_A : STOP_CYCLES;
  localparam int  CW      = $clog2(MAX_C + 1);
  localparam bit  FREQ_OK = (CLK_MHZ >= MIN_DLL_MHZ);
  localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_CYCLES - 1);
  localparam logic [CW-1:0] STOP_LAST = CW'(STOP_CYCLES - 1);
  localparam logic [CW-1:0] TMO_LAST  = CW'(PG_TIMEOUT - 1);

  logic [4:0] raw_in, syn_in;
  logic core_s, io_s, vref_s, stable_s, freq_s;

  assign raw_in = {freq_chg_req, clk_stable, vref_pg, io_pg, core_pg};

  mps_sync #(.W(5), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  assign {freq_s, stable_s, vref_s, io_s, core_s} = syn_in;

  mps_state_e st, nxt;
  logic [CW-1:0] cnt;
  logic tmo;

  mps_timer #(.W(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(nxt != st), .cnt(cnt)
  );

  assign tmo = (cnt == TMO_LAST);

  always_comb begin
    nxt = st;
    unique case (st)
      ST_OFF:  nxt = ST_CORE;
      ST_CORE: begin
        if (core_s)   nxt = ST_IO;
        else if (tmo) nxt = ST_FAULT;
      end
      ST_IO: begin
        if (io_s && (!vref_with_io || vref_s)) nxt = vref_with_io ? ST_CLKWAIT : ST_VREF;
        else if (tmo)                          nxt = ST_FAULT;
      end
      ST_VREF: begin
        if (vref_s)   nxt = ST_CLKWAIT;
        else if (tmo) nxt = ST_FAULT;
      end
      ST_CLKWAIT: begin
        if (stable_s) begin
          if (!FREQ_OK)          nxt = ST_FAULT;
          else if (dll_strap_hi) nxt = ST_STOP;
          else                   nxt = ST_LOCK;
        end
      end
      ST_STOP: begin
        if (!stable_s)              nxt = ST_CLKWAIT;
        else if (cnt == STOP_LAST)  nxt = ST_LOCK;
      end
      ST_LOCK: begin
        if (freq_s || !stable_s)    nxt = ST_CLKWAIT;
        else if (cnt == LOCK_LAST)  nxt = ST_READY;
      end
      ST_READY: begin
        if (freq_s || !stable_s)    nxt = ST_CLKWAIT;
      end
      default: nxt = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_OFF;
    else        st <= nxt;
  end

  logic up_phase;
  assign up_phase = st inside {ST_CLKWAIT, ST_STOP, ST_LOCK, ST_READY};

  assign core_en   = (st inside {ST_CORE, ST_IO, ST_VREF}) || up_phase;
  assign io_en     = (st inside {ST_IO, ST_VREF}) || up_phase;
  assign vref_en   = (st == ST_VREF) || (st == ST_IO && vref_with_io) || up_phase;
  assign dll_on    = st inside {ST_LOCK, ST_READY};
  assign mclk_run  = st inside {ST_CLKWAIT, ST_LOCK, ST_READY};
  assign ready     = (st == ST_READY);
  assign fault     = (st == ST_FAULT);
  assign state_dbg = st;
endmodule

// File: rtl/mps_checker.sv
module mps_checker #(
  parameter int LOCK_CYCLES = 1024
) (
  input logic clk,
  input logic rst_n,
  input logic core_en,
  input logic io_en,
  input logic vref_en,
  input logic dll_on,
  input logic mclk_run,
  input logic ready,
  input logic fault
);
  int unsigned dll_age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   dll_age <= 0;
    else if (!dll_on)             dll_age <= 0;
    else if (dll_age < 32'hFFFF)  dll_age <= dll_age + 1;
  end

  a_r2_rail_order: assert property (@(posedge clk) disable iff (!rst_n)
    (io_en |-> core_en) and (vref_en && !io_en |-> 1'b0));

  a_r4_dll_after_rails: assert property (@(posedge clk) disable iff (!rst_n)
    dll_on |-> (core_en && io_en && vref_en));

  a_r5_lock_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (dll_on && dll_age == LOCK_CYCLES));

  a_r6_dll_with_clock: assert property (@(posedge clk) disable iff (!rst_n)
    dll_on |-> mclk_run);

  a_r10_fault_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !(core_en || io_en || vref_en || dll_on || ready));

  a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);
endmodule

bind mem_pwrup_seq mps_checker #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_en(core_en), .io_en(io_en), .vref_en(vref_en),
  .dll_on(dll_on), .mclk_run(mclk_run), .ready(ready), .fault(fault)
);

// File: tb/tb_mem_pwrup_seq.sv
module tb_mem_pwrup_seq;
  localparam int LOCK = 1024;
  localparam int STOP = 6;
  localparam int TMO  = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_pg = 0, io_pg = 0, vref_pg = 0, clk_stable = 0, freq_chg_req = 0;
  logic dll_strap_hi = 0, vref_with_io = 0;

  logic core_en, io_en, vref_en, dll_on, mclk_run, ready, fault;
  logic [3:0] state_dbg;
  logic s_core_en, s_io_en, s_vref_en, s_dll_on, s_mclk_run, s_ready, s_fault;
  logic [3:0] s_state;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  mem_pwrup_seq dut (
    .clk(clk), .rst_n(rst_n), .core_pg(core_pg), .io_pg(io_pg), .vref_pg(vref_pg),
    .clk_stable(clk_stable), .freq_chg_req(freq_chg_req), .dll_strap_hi(dll_strap_hi),
    .vref_with_io(vref_with_io), .core_en(core_en), .io_en(io_en), .vref_en(vref_en),
    .dll_on(dll_on), .mclk_run(mclk_run), .ready(ready), .fault(fault), .state_dbg(state_dbg)
  );

  mem_pwrup_seq #(.CLK_MHZ(100)) dut_slow (
    .clk(clk), .rst_n(rst_n), .core_pg(core_pg), .io_pg(io_pg), .vref_pg(vref_pg),
    .clk_stable(clk_stable), .freq_chg_req(freq_chg_req), .dll_strap_hi(dll_strap_hi),
    .vref_with_io(vref_with_io), .core_en(s_core_en), .io_en(s_io_en), .vref_en(s_vref_en),
    .dll_on(s_dll_on), .mclk_run(s_mclk_run), .ready(s_ready), .fault(s_fault), .state_dbg(s_state)
  );

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {core_pg, io_pg, vref_pg, clk_stable, freq_chg_req} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_dll_rise();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (dll_on) break;
    end
  endtask

  task automatic count_to_ready(string rq);
    int k = 0;
    while (!ready && k < 3000) begin
      @(negedge clk);
      k++;
    end
    chk(rq, k, LOCK);
  endtask

  task automatic bring_to_lock();
    do_reset();
    core_pg = 1; io_pg = 1; vref_pg = 1;
    repeat (15) @(negedge clk);
    clk_stable = 1;
    wait_dll_rise();
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 enables", {core_en, io_en, vref_en}, 0);
    chk("R1 dll/ready/fault", {dll_on, ready, fault}, 0);
    chk("R1 mclk_run", mclk_run, 0);
    chk("R1 R11 state off", state_dbg, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_normal();
    dll_strap_hi = 0; vref_with_io = 0;
    do_reset();
    @(negedge clk);
    chk("R2 R11 core state", state_dbg, 1);
    chk("R2 only core_en", {core_en, io_en, vref_en}, 3'b100);
    core_pg = 1;
    repeat (10) @(negedge clk);
    chk("R2 R11 io state", state_dbg, 2);
    chk("R2 io after core", {core_en, io_en, vref_en}, 3'b110);
    io_pg = 1;
    repeat (10) @(negedge clk);
    chk("R2 R11 vref state", state_dbg, 3);
    chk("R2 vref after io", {core_en, io_en, vref_en}, 3'b111);
    vref_pg = 1;
    repeat (10) @(negedge clk);
    chk("R4 R11 clock wait", state_dbg, 4);
    chk("R4 dll low w/o clock", dll_on, 0);
    chk("R4 clock running", mclk_run, 1);
    clk_stable = 1;
    wait_dll_rise();
    chk("R4 R11 lock state", state_dbg, 6);
    count_to_ready("R5 lock length");
    chk("R11 ready state", state_dbg, 7);
    // slow-clock instance saw the same stimulus
    chk("R9 slow fault", s_fault, 1);
    chk("R9 slow dll off", s_dll_on, 0);
    chk("R9 slow state", s_state, 8);
  endtask

  task automatic t_vref_io();
    int saw3 = 0;
    dll_strap_hi = 0; vref_with_io = 1;
    do_reset();
    core_pg = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (io_en) break;
    end
    chk("R3 vref with io", {io_en, vref_en}, 2'b11);
    io_pg = 1;
    repeat (10) @(negedge clk);
    chk("R3 waits vref pg", state_dbg, 2);
    vref_pg = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (state_dbg == 3) saw3 = 1;
    end
    chk("R3 no state 3", saw3, 0);
    chk("R3 reaches clock wait", state_dbg, 4);
    vref_with_io = 0;
  endtask

  task automatic t_strap();
    int k = 0;
    dll_strap_hi = 1;
    do_reset();
    core_pg = 1; io_pg = 1; vref_pg = 1;
    repeat (15) @(negedge clk);
    clk_stable = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!mclk_run) break;
    end
    chk("R6 R11 stop state", state_dbg, 5);
    chk("R6 dll low in stop", dll_on, 0);
    while (!mclk_run && k < 100) begin
      @(negedge clk);
      k++;
    end
    chk("R6 stop length", k, STOP);
    chk("R6 dll with clock", dll_on, 1);
    count_to_ready("R5 R6 lock after stop");
    dll_strap_hi = 0;
  endtask

  task automatic t_freq();
    dll_strap_hi = 0;
    bring_to_lock();
    repeat (LOCK - 3) @(negedge clk);
    freq_chg_req = 1;
    @(negedge clk);
    freq_chg_req = 0;
    @(negedge clk);
    chk("R7 still locking", state_dbg, 6);
    @(negedge clk);
    chk("R7 request wins", ready, 0);
    chk("R7 back to clock wait", state_dbg, 4);
    chk("R7 dll dropped", dll_on, 0);
    wait_dll_rise();
    count_to_ready("R7 full recount");
    freq_chg_req = 1;
    @(negedge clk);
    freq_chg_req = 0;
    repeat (3) @(negedge clk);
    chk("R7 ready dropped", ready, 0);
  endtask

  task automatic t_clkdrop();
    bring_to_lock();
    count_to_ready("R5 before drop");
    clk_stable = 0;
    repeat (6) @(negedge clk);
    chk("R8 ready dropped", ready, 0);
    chk("R8 state clock wait", state_dbg, 4);
    clk_stable = 1;
    wait_dll_rise();
    repeat (100) @(negedge clk);
    clk_stable = 0;
    repeat (6) @(negedge clk);
    chk("R8 drop in lock", {dll_on, state_dbg}, 5'h04);
    clk_stable = 1;
    wait_dll_rise();
    count_to_ready("R8 restarted count");
  endtask

  task automatic t_timeout();
    int k = 0;
    do_reset();
    @(negedge clk);
    while (!fault && k < 500) begin
      @(negedge clk);
      k++;
    end
    chk("R10 timeout cycles", k, TMO);
    chk("R10 enables off", {core_en, io_en, vref_en, dll_on}, 0);
    core_pg = 1; io_pg = 1; vref_pg = 1; clk_stable = 1;
    repeat (20) @(negedge clk);
    chk("R10 sticky fault", {fault, state_dbg}, 5'h18);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_vref_io();
    t_strap();
    t_freq();
    t_clkdrop();
    t_timeout();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule